// File: doc/BRIEF.md
# Three-Line Vertical Anti-Flicker Filter

This block smooths a raster of 24-bit RGB pixels in the vertical direction so that thin horizontal detail does not flicker when the picture is later shown interlaced. For each pixel column it combines the line above, the current line and the line below with one of four weightings chosen by a 2-bit mode input. It then divides the weighted sum by the total weight with round-to-nearest, and clamps the result to 8 bits. The red, green and blue channels are each 8 bits and are filtered separately.

Pixels arrive one per accepted clock with a valid strobe, a line-start marker on column 0 of every line and a frame-start marker on column 0 of the first line of each frame. Two internal line stores hold the previous two lines, so line `y` is emitted while line `y+1` arrives. The last line of a frame is emitted while the first line of the next frame arrives. The line length is fixed by the parameter `LINE_LEN`. The mode is sampled only when a line starts, so every output line uses a single weighting.

Top module: `vflick_filter`

## Requirements
- R1: Mode 2'b00 passes the centre line through unchanged (weights 0:1:0).
- R2: Mode 2'b01 outputs (above + 3*centre + below + 2) / 5, using integer division.
- R3: Mode 2'b10 outputs (above + 2*centre + below + 2) / 4, which rounds halves upward.
- R4: Mode 2'b11 outputs (above + centre + below + 1) / 3.
- R5: The three channels are filtered independently. Red is in bits [23:16], green in [15:8] and blue in [7:0].
- R6: For the first line of a frame (the line whose column 0 carried in_sof), the centre line is used in place of the line above.
- R7: For the last line of a frame (the line followed by a line whose column 0 carries in_sof), the centre line is used in place of the line below.
- R8: The mode applied to output line y is the in_mode value present with column 0 of input line y+1. Changes to in_mode in the middle of a line have no effect on that line.
- R9: The output for pixel (y, x) appears with out_valid high one rising edge after the edge that accepts input pixel (y+1, x). out_sol is high exactly for column 0, and out_valid is never high at any other time.
- R10: After reset, out_valid, out_sol and out_rgb are 0. No output is produced while the first line after reset is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sol | input | 1 | Input pixel is column 0 of a line |
| in_sof | input | 1 | Input pixel is column 0 of a frame's first line |
| in_mode | input | 2 | Weighting select, sampled at line start |
| in_rgb | input | 24 | Input pixel, R in [23:16], G [15:8], B [7:0] |
| out_valid | output | 1 | Filtered pixel present |
| out_sol | output | 1 | Filtered pixel is column 0 |
| out_rgb | output | 24 | Filtered pixel |

## Verification
A filtered pixel is due exactly one rising edge after the edge that accepts the pixel in the same column of the following line. A line therefore only appears once the next line, or the next frame's first line, is sent. The bench records the acceptance edge of every input pixel and the edge at which each output is observed. It requires the difference to be exactly one, and it requires the number of outputs to match the number of completed lines. These checks apply both to back-to-back input and to input with idle gaps. Output values are sampled on the falling edge, half a cycle after the register that drives them has updated. Each value is compared against weights that the bench computes from the mode sent at the start of the following line.

// File: rtl/vflick_filter.sv
module vflick_filter #(
  parameter int LINE_LEN = 640,
  parameter int CW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sol,
  input  logic              in_sof,
  input  logic [1:0]        in_mode,
  input  logic [3*CW-1:0]   in_rgb,
  output logic              out_valid,
  output logic              out_sol,
  output logic [3*CW-1:0]   out_rgb
);
  localparam int PW = 3 * CW;
  localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam int SW = CW + 3;
  localparam logic [AW-1:0] LAST_COL = AW'(LINE_LEN - 1);

  logic [PW-1:0] lb_cen [LINE_LEN];
  logic [PW-1:0] lb_abv [LINE_LEN];

  logic [AW-1:0] col;
  logic          seen, inc_first;
  logic          act_r, top_r, bot_r;
  logic [1:0]    mode_r;

  logic [PW-1:0] s1_a, s1_c, s1_b;
  logic [1:0]    s1_mode;
  logic          s1_v, s1_sol;
  logic [PW-1:0] mix;

  wire [AW-1:0] addr    = in_sol ? '0 : col;
  wire          act_now = in_sol ? seen      : act_r;
  wire          top_now = in_sol ? inc_first : top_r;
  wire          bot_now = in_sol ? in_sof    : bot_r;
  wire [1:0]    mode_now = in_sol ? in_mode  : mode_r;
  wire [PW-1:0] cen_rd  = lb_cen[addr];
  wire [PW-1:0] abv_rd  = lb_abv[addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) col <= '0;
    else if (in_valid) col <= (addr == LAST_COL) ? '0 : addr + AW'(1);

  always_ff @(posedge clk)
    if (in_valid) begin
      lb_abv[addr] <= cen_rd;
      lb_cen[addr] <= in_rgb;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen      <= 1'b0;
      inc_first <= 1'b0;
      act_r     <= 1'b0;
      top_r     <= 1'b0;
      bot_r     <= 1'b0;
      mode_r    <= 2'b00;
    end else if (in_valid && in_sol) begin
      seen      <= 1'b1;
      inc_first <= in_sof;
      act_r     <= seen;
      top_r     <= inc_first;
      bot_r     <= in_sof;
      mode_r    <= in_mode;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_sol  <= 1'b0;
      s1_mode <= 2'b00;
      s1_a    <= '0;
      s1_c    <= '0;
      s1_b    <= '0;
    end else begin
      s1_v <= in_valid && act_now;
      if (in_valid) begin
        s1_sol  <= in_sol;
        s1_mode <= mode_now;
        s1_a    <= top_now ? cen_rd : abv_rd;
        s1_c    <= cen_rd;
        s1_b    <= bot_now ? cen_rd : in_rgb;
      end
    end

  function automatic logic [CW-1:0] blend(input logic [1:0] m,
                                          input logic [CW-1:0] a,
                                          input logic [CW-1:0] c,
                                          input logic [CW-1:0] b);
    logic [SW-1:0] s, q;
    s = '0;
    q = '0;
    case (m)
      2'b00: q = SW'(c);
      2'b01: begin
        s = SW'(a) + SW'(c) * SW'(3) + SW'(b);
        q = (s + SW'(2)) / SW'(5);
      end
      2'b10: begin
        s = SW'(a) + SW'(c) * SW'(2) + SW'(b);
        q = (s + SW'(2)) >> 2;
      end
      default: begin
        s = SW'(a) + SW'(c) + SW'(b);
        q = (s + SW'(1)) / SW'(3);
      end
    endcase
    if (q > SW'({CW{1'b1}})) q = SW'({CW{1'b1}});
    return q[CW-1:0];
  endfunction

  for (genvar k = 0; k < 3; k++) begin : g_ch
    assign mix[k*CW +: CW] = blend(s1_mode, s1_a[k*CW +: CW],
                                   s1_c[k*CW +: CW], s1_b[k*CW +: CW]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= s1_v;
      out_sol   <= s1_v && s1_sol;
      if (s1_v) out_rgb <= mix;
    end
endmodule

// File: rtl/vflick_filter_chk.sv
module vflick_filter_chk #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sol,
  input logic          out_valid,
  input logic          out_sol,
  input logic [PW-1:0] out_rgb
);
  logic sol_seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sol_seen <= 1'b0;
    else if (in_valid && in_sol) sol_seen <= 1'b1;

  a_r9_valid_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  a_r9_sol_from_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> (out_valid && $past(in_valid && in_sol, 2)));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_rgb));

  a_r10_quiet_first_line: assert property (@(posedge clk) disable iff (!rst_n)
    !sol_seen |-> !out_valid);
endmodule

bind vflick_filter vflick_filter_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
  .out_valid(out_valid), .out_sol(out_sol), .out_rgb(out_rgb)
);

// File: tb/vflick_filter_tb.sv
module vflick_filter_tb_top;
  localparam int LL   = 6;
  localparam int MAXL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic [1:0] in_mode = 2'b00;
  logic [23:0] in_rgb = '0;
  logic out_valid, out_sol;
  logic [23:0] out_rgb;

  vflick_filter #(.LINE_LEN(LL), .CW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .in_mode(in_mode), .in_rgb(in_rgb),
    .out_valid(out_valid), .out_sol(out_sol), .out_rgb(out_rgb));

  always #4 clk = ~clk;

  int total = 0, bad = 0, edge_cnt = 0, cap_n = 0;
  bit done = 0;
  logic [23:0] img [MAXL][LL];
  int lmode [MAXL];
  int mmode [MAXL];
  int acc_edge [MAXL*LL];
  int cap_cyc [64];
  logic [23:0] cap_rgb [64];
  logic cap_sol [64];

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  always @(negedge clk)
    if (rst_n && out_valid && cap_n < 64) begin
      cap_rgb[cap_n] = out_rgb;
      cap_sol[cap_n] = out_sol;
      cap_cyc[cap_n] = edge_cnt;
      cap_n = cap_n + 1;
    end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ech(int m, int a, int c, int b);
    case (m)
      0: return c;
      1: return (a + 3*c + b + 2) / 5;
      2: return (a + 2*c + b + 2) / 4;
      default: return (a + b + c + 1) / 3;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 0; in_sol = 0; in_sof = 0; in_mode = 0; in_rgb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cap_n = 0;
    for (int i = 0; i < MAXL; i++) mmode[i] = -1;
  endtask

  task automatic fill(int n, int seed, int m);
    for (int y = 0; y <= n; y++) begin
      lmode[y] = m;
      for (int x = 0; x < LL; x++)
        for (int k = 0; k < 3; k++)
          img[y][x][k*8 +: 8] = 8'((seed*37 + y*53 + x*29 + k*71 + y*x*13) & 255);
    end
  endtask

  task automatic send_lines(int first, int last, int sof_a, int sof_b, bit gaps);
    for (int y = first; y <= last; y++)
      for (int x = 0; x < LL; x++) begin
        @(negedge clk);
        in_valid = 1;
        in_sol = (x == 0);
        in_sof = (x == 0) && (y == sof_a || y == sof_b);
        in_mode = 2'((x == 0 || mmode[y] < 0) ? lmode[y] : mmode[y]);
        in_rgb = img[y][x];
        acc_edge[y*LL + x] = edge_cnt + 1;
        if (gaps && (x % 2 == 1)) begin
          @(negedge clk);
          in_valid = 0; in_sol = 0; in_sof = 0;
        end
      end
    @(negedge clk);
    in_valid = 0; in_sol = 0; in_sof = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_frame(int n, string req);
    chk(cap_n == n*LL, req, "output count", cap_n, n*LL);
    for (int i = 0; i < cap_n && i < n*LL; i++) begin
      int y = i / LL, x = i % LL, m = lmode[y+1];
      logic [23:0] e;
      for (int k = 0; k < 3; k++) begin
        int c = img[y][x][k*8 +: 8];
        int a = (y == 0) ? c : int'(img[y-1][x][k*8 +: 8]);
        int b = (y == n-1) ? c : int'(img[y+1][x][k*8 +: 8]);
        e[k*8 +: 8] = 8'(ech(m, a, c, b));
      end
      chk(cap_rgb[i] == e, req, $sformatf("pixel y%0d x%0d", y, x), int'(cap_rgb[i]), int'(e));
      chk(cap_sol[i] == (x == 0), "R9", "out_sol", int'(cap_sol[i]), int'(x == 0));
      chk(cap_cyc[i] == acc_edge[i + LL] + 1, "R9", "latency edge",
          cap_cyc[i], acc_edge[i + LL] + 1);
    end
  endtask

  task automatic frame_test(int n, int seed, int m, string req, bit gaps);
    do_reset();
    fill(n, seed, m);
    send_lines(0, n, 0, n, gaps);
    check_frame(n, req);
  endtask

  task automatic t_reset();
    do_reset();
    chk(out_valid == 0, "R10", "out_valid after reset", int'(out_valid), 0);
    chk(out_sol == 0, "R10", "out_sol after reset", int'(out_sol), 0);
    chk(out_rgb == 0, "R10", "out_rgb after reset", int'(out_rgb), 0);
    fill(1, 3, 1);
    send_lines(0, 0, 0, 0, 0);
    chk(cap_n == 0, "R10", "outputs during first line", cap_n, 0);
  endtask

  task automatic t_single_line();
    do_reset();
    fill(1, 9, 1);
    send_lines(0, 1, 0, 1, 0);
    check_frame(1, "R6 R7");
  endtask

  task automatic t_channels();
    do_reset();
    fill(3, 0, 3);
    for (int y = 0; y <= 3; y++)
      for (int x = 0; x < LL; x++)
        img[y][x] = {8'(y*80 + x), 8'hFF, 8'h00};
    send_lines(0, 3, 0, 3, 0);
    check_frame(3, "R5");
    for (int i = 0; i < cap_n; i++) begin
      chk(cap_rgb[i][15:8] == 8'hFF, "R5", "green held", int'(cap_rgb[i][15:8]), 255);
      chk(cap_rgb[i][7:0] == 8'h00, "R5", "blue held", int'(cap_rgb[i][7:0]), 0);
    end
  endtask

  task automatic t_mode_switch();
    do_reset();
    fill(4, 5, 0);
    lmode[1] = 1; mmode[1] = 3;
    lmode[2] = 3; mmode[2] = 0;
    lmode[3] = 2; mmode[3] = 1;
    lmode[4] = 0; mmode[4] = 2;
    send_lines(0, 4, 0, 4, 0);
    check_frame(4, "R8");
  endtask

  task automatic t_two_frames();
    do_reset();
    fill(5, 11, 1);
    send_lines(0, 5, 0, 2, 0);
    chk(cap_n == 5*LL, "R7", "count across frames", cap_n, 5*LL);
    for (int x = 0; x < LL; x++) begin
      int c = img[1][x][23:16], a = img[0][x][23:16];
      int e = ech(1, a, c, c);
      chk(int'(cap_rgb[LL + x][23:16]) == e, "R7", "last line of frame A", int'(cap_rgb[LL + x][23:16]), e);
      c = img[2][x][23:16];
      e = ech(1, c, c, int'(img[3][x][23:16]));
      chk(int'(cap_rgb[2*LL + x][23:16]) == e, "R6", "first line of frame B", int'(cap_rgb[2*LL + x][23:16]), e);
    end
  endtask

  initial begin
    t_reset();
    frame_test(4, 1, 0, "R1", 0);
    frame_test(4, 2, 1, "R2", 0);
    frame_test(4, 3, 2, "R3", 0);
    frame_test(4, 4, 3, "R4", 0);
    frame_test(3, 7, 1, "R9", 1);
    t_single_line();
    t_channels();
    t_mode_switch();
    t_two_frames();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule